// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns 32-bit device virtual addresses into physical addresses. A virtual address splits into three fields: bits 31:22 select one of 1024 four-byte words in a directory page, bits 21:12 select one of 1024 four-byte words in a page table, and bits 11:0 are the byte offset inside a 4 KB page. The walker issues one 32-bit memory read for the directory word and, if that word is valid, a second read for the page word. It then returns the physical address with the page's attribute flags, a page fault, or a bus error.

Completed translations go into a small fully associative translation cache. A later request to the same page is answered from the cache without touching memory. Software can drop a single page from the cache or clear the whole cache. A page fault also latches the faulting address and access direction until it is acknowledged, and no new request is accepted until then.

The request, response and memory-read interfaces are valid/ready. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. The response holds `rsp_valid` and its payload unchanged until `rsp_ready` is seen high. A memory read request holds its address until `mem_req_ready`. The memory returns exactly one `mem_rsp_valid` beat per accepted read and may not be back-pressured. `dir_base_frame` must stay stable while a walk is in progress.

Top module: `pt_walker`

## Requirements
- R1: The directory word is read from address {dir_base_frame, va[31:22], 2'b00}, which is base + 4 × va[31:22]. The memory address stays stable while the request waits for `mem_req_ready`.
- R2: For a valid directory word D (D[0]=1), the page word P is read from {D[31:12], va[21:12], 2'b00}. If P is valid and allowed, the response has `rsp_status`=0, `rsp_pa`={P[31:12], va[11:0]} and `rsp_attr`=P[8:1].
- R3: A directory word with bit 0 clear gives `rsp_status`=1 (page fault) with no second read. A page word with bit 0 clear also gives status 1.
- R4: A read needs P[1] (readable) and a write needs P[2] (writable). Without that bit the result is status 1. This applies to cache hits as well as to walks.
- R5: On status 1, `flt_pending` rises together with `rsp_valid`. `flt_va` and `flt_write` hold the request's address and direction until a cycle with `flt_ack` high. While `flt_pending` is high, `req_ready` is low.
- R6: A memory response with `mem_rsp_err` ends the walk with `rsp_status`=2 and a one-cycle `bus_err` pulse aligned with the first `rsp_valid` cycle. `flt_pending` is not set.
- R7: A request whose page is cached is answered with `rsp_valid` in the cycle right after acceptance, with no memory read. The cache has TLB_ENTRIES (default 8) entries.
- R8: Cache fills use round-robin replacement. After a full clear, the (TLB_ENTRIES+1)-th distinct page evicts the first page filled, and the other pages stay cached.
- R9: A cycle with `inv_page` high removes only the entry whose page number equals `inv_vpn`. Other entries keep hitting.
- R10: A cycle with `flush_all` high removes every entry. A clear wins over a fill in the same cycle.
- R11: `req_ready` is low while a walk or an undelivered response is in progress, and while `stall` is high.
- R12: While `rsp_valid` is high and `rsp_ready` is low, the response payload holds stable.
- R13: After reset, `req_ready` is 1 and `rsp_valid`, `mem_req_valid`, `flt_pending` and `bus_err` are 0. The cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | Holds off new requests |
| dir_base_frame | input | 20 | Page frame number of the directory |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can take a request |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_status | output | 2 | 0 ok, 1 page fault, 2 bus error |
| rsp_pa | output | 32 | Physical address (0 unless ok) |
| rsp_attr | output | 8 | Page word bits 8:1 (0 unless ok) |
| flt_pending | output | 1 | Page fault waiting for acknowledge |
| flt_va | output | 32 | Faulting virtual address |
| flt_write | output | 1 | Faulting access was a write |
| flt_ack | input | 1 | Acknowledge and clear the fault |
| bus_err | output | 1 | One-cycle bus error event |
| inv_page | input | 1 | Invalidate one cached page |
| inv_vpn | input | 20 | Page number to invalidate |
| flush_all | input | 1 | Invalidate the whole cache |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Word address of the read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| mem_rsp_err | input | 1 | Read ended in an error |

## Verification
A cache hit must show `rsp_valid` at the first sample after the accepting edge. A walk takes a variable number of cycles set by the memory's ready and latency. The bench therefore waits for `rsp_valid` on falling edges and judges walks by the count and addresses of the memory reads they caused, not by latency. `bus_err` and `flt_pending` are sampled in the same falling-edge slot as the first `rsp_valid`. The fault clear is sampled one cycle after `flt_ack`. Cache invalidation is judged at the ports by changing a page word in memory and watching whether the next request reads memory and returns the old or the new frame.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ADDR_W = 32;
  localparam int OFF_W  = 12;
  localparam int IDX_W  = 10;
  localparam int VPN_W  = ADDR_W - OFF_W;
  localparam int ATTR_W = 8;

  typedef enum logic [1:0] {
    XS_OK     = 2'd0,
    XS_PFAULT = 2'd1,
    XS_BUSERR = 2'd2
  } xl_status_e;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [VPN_W-1:0]  ppn;
    logic [ATTR_W-1:0] attr;
  } tlb_ent_t;

  // attr[0] is page word bit 1 (readable), attr[1] is bit 2 (writable)
  function automatic logic perm_ok(input logic [ATTR_W-1:0] attr, input logic wr);
    return wr ? attr[1] : attr[0];
  endfunction
endpackage

// File: rtl/ptw_tlb.sv
module ptw_tlb
  import ptw_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output tlb_ent_t         lk_ent,
  input  logic             fill_en,
  input  tlb_ent_t         fill_ent,
  input  logic             inv_en,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             flush
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_vec;
  logic [ENTRIES-1:0] hit_vec;
  tlb_ent_t           ent_arr [ENTRIES];
  logic [PTR_W-1:0]   rr_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic     v_q;
    tlb_ent_t e_q;
    logic     take;
    logic     kill;

    assign take = fill_en && (rr_q == PTR_W'(g));
    // a clear applies to the value the entry would hold after this cycle's fill
    assign kill = flush || (inv_en && ((take ? fill_ent.vpn : e_q.vpn) == inv_vpn));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        e_q <= '0;
      end else begin
        if (take) e_q <= fill_ent;
        if (kill)      v_q <= 1'b0;
        else if (take) v_q <= 1'b1;
      end
    end

    assign vld_vec[g] = v_q;
    assign ent_arr[g] = e_q;
    assign hit_vec[g] = v_q && (e_q.vpn == lk_vpn);
  end

  always_comb begin
    lk_ent = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) lk_ent = tlb_ent_t'(lk_ent | ent_arr[i]);
    end
  end
  assign lk_hit = |hit_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rr_q <= '0;
    else if (fill_en) begin
      if (rr_q == PTR_W'(ENTRIES - 1)) rr_q <= '0;
      else                             rr_q <= rr_q + 1'b1;
    end
  end

  // R7: a page is never cached twice
  assert_single_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R10: nothing survives a full clear
  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_vec == '0));

  // R9: the invalidated page no longer hits in the next cycle
  assert_inv_gone_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && (lk_vpn == inv_vpn)) ##1 $stable(lk_vpn) |-> !lk_hit);
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic [VPN_W-1:0]  dir_base_frame,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_va,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_status,
  output logic [ADDR_W-1:0] rsp_pa,
  output logic [ATTR_W-1:0] rsp_attr,
  output logic              flt_pending,
  output logic [ADDR_W-1:0] flt_va,
  output logic              flt_write,
  input  logic              flt_ack,
  output logic              bus_err,
  input  logic              tlb_hit,
  input  tlb_ent_t          tlb_ent,
  output logic              fill_en,
  output tlb_ent_t          fill_ent,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  input  logic              mem_rsp_err
);
  typedef enum logic [2:0] {
    S_IDLE, S_DIR_RD, S_DIR_WT, S_PTE_RD, S_PTE_WT, S_RESP
  } wstate_e;

  wstate_e           state_q;
  logic [ADDR_W-1:0] va_q;
  logic              wr_q;
  logic [VPN_W-1:0]  tbl_q;
  logic [1:0]        st_q;
  logic [ADDR_W-1:0] pa_q;
  logic [ATTR_W-1:0] attr_q;
  logic              fpend_q;
  logic [ADDR_W-1:0] fva_q;
  logic              fwr_q;
  logic              berr_q;

  logic              acc;
  logic              fin_en;
  xl_status_e        fin_st;
  logic [ADDR_W-1:0] fin_pa;
  logic [ATTR_W-1:0] fin_attr;
  logic [ATTR_W-1:0] pte_attr;
  logic              unused_bits;

  assign unused_bits = ^mem_rsp_data[11:9];
  assign pte_attr    = mem_rsp_data[8:1];

  assign req_ready     = (state_q == S_IDLE) && !stall && !fpend_q;
  assign acc           = req_valid && req_ready;
  assign rsp_valid     = (state_q == S_RESP);
  assign mem_req_valid = (state_q == S_DIR_RD) || (state_q == S_PTE_RD);
  assign mem_req_addr  = (state_q == S_DIR_RD)
                       ? {dir_base_frame, va_q[31:22], 2'b00}
                       : {tbl_q, va_q[21:12], 2'b00};

  assign fill_en       = (state_q == S_PTE_WT) && mem_rsp_valid && !mem_rsp_err && mem_rsp_data[0];
  assign fill_ent.vpn  = va_q[31:12];
  assign fill_ent.ppn  = mem_rsp_data[31:12];
  assign fill_ent.attr = pte_attr;

  always_comb begin
    fin_en   = 1'b0;
    fin_st   = XS_OK;
    fin_pa   = '0;
    fin_attr = '0;
    unique case (state_q)
      S_IDLE: if (acc && tlb_hit) begin
        fin_en = 1'b1;
        if (perm_ok(tlb_ent.attr, req_write)) begin
          fin_pa   = {tlb_ent.ppn, req_va[OFF_W-1:0]};
          fin_attr = tlb_ent.attr;
        end else begin
          fin_st = XS_PFAULT;
        end
      end
      S_DIR_WT: if (mem_rsp_valid) begin
        if (mem_rsp_err) begin
          fin_en = 1'b1;
          fin_st = XS_BUSERR;
        end else if (!mem_rsp_data[0]) begin
          fin_en = 1'b1;
          fin_st = XS_PFAULT;
        end
      end
      S_PTE_WT: if (mem_rsp_valid) begin
        fin_en = 1'b1;
        if (mem_rsp_err) begin
          fin_st = XS_BUSERR;
        end else if (!mem_rsp_data[0] || !perm_ok(pte_attr, wr_q)) begin
          fin_st = XS_PFAULT;
        end else begin
          fin_pa   = {mem_rsp_data[31:12], va_q[OFF_W-1:0]};
          fin_attr = pte_attr;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      tbl_q   <= '0;
      st_q    <= 2'd0;
      pa_q    <= '0;
      attr_q  <= '0;
      fpend_q <= 1'b0;
      fva_q   <= '0;
      fwr_q   <= 1'b0;
      berr_q  <= 1'b0;
    end else begin
      berr_q <= 1'b0;
      unique case (state_q)
        S_IDLE:   if (acc) begin
          va_q    <= req_va;
          wr_q    <= req_write;
          state_q <= tlb_hit ? S_RESP : S_DIR_RD;
        end
        S_DIR_RD: if (mem_req_ready) state_q <= S_DIR_WT;
        S_DIR_WT: if (mem_rsp_valid) begin
          tbl_q <= mem_rsp_data[31:12];
          if (!fin_en) state_q <= S_PTE_RD;
        end
        S_PTE_RD: if (mem_req_ready) state_q <= S_PTE_WT;
        S_RESP:   if (rsp_ready) state_q <= S_IDLE;
        default:  ;
      endcase

      if (fin_en) begin
        state_q <= S_RESP;
        st_q    <= fin_st;
        pa_q    <= fin_pa;
        attr_q  <= fin_attr;
        if (fin_st == XS_BUSERR) berr_q <= 1'b1;
        if (fin_st == XS_PFAULT) begin
          fpend_q <= 1'b1;
          fva_q   <= (state_q == S_IDLE) ? req_va : va_q;
          fwr_q   <= (state_q == S_IDLE) ? req_write : wr_q;
        end
      end else if (flt_ack) begin
        fpend_q <= 1'b0;
      end
    end
  end

  assign rsp_status  = st_q;
  assign rsp_pa      = pa_q;
  assign rsp_attr    = attr_q;
  assign flt_pending = fpend_q;
  assign flt_va      = fva_q;
  assign flt_write   = fwr_q;
  assign bus_err     = berr_q;

  assert_stall_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !req_ready);

  assert_fault_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flt_pending |-> !req_ready);

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_status) && $stable(rsp_attr));

  assert_mem_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_hit_fast_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && tlb_hit |=> rsp_valid && !mem_req_valid);

  assert_berr_nofault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> !flt_pending && rsp_valid);

  assert_berr_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> !bus_err);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int TLB_ENTRIES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stall,
  input  logic [19:0] dir_base_frame,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  input  logic        req_write,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [1:0]  rsp_status,
  output logic [31:0] rsp_pa,
  output logic [7:0]  rsp_attr,
  output logic        flt_pending,
  output logic [31:0] flt_va,
  output logic        flt_write,
  input  logic        flt_ack,
  output logic        bus_err,
  input  logic        inv_page,
  input  logic [19:0] inv_vpn,
  input  logic        flush_all,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  input  logic        mem_rsp_err
);
  logic     tlb_hit;
  tlb_ent_t tlb_ent;
  logic     fill_en;
  tlb_ent_t fill_ent;

  ptw_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_vpn   (req_va[31:12]),
    .lk_hit   (tlb_hit),
    .lk_ent   (tlb_ent),
    .fill_en  (fill_en),
    .fill_ent (fill_ent),
    .inv_en   (inv_page),
    .inv_vpn  (inv_vpn),
    .flush    (flush_all)
  );

  ptw_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .stall          (stall),
    .dir_base_frame (dir_base_frame),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_va         (req_va),
    .req_write      (req_write),
    .rsp_valid      (rsp_valid),
    .rsp_ready      (rsp_ready),
    .rsp_status     (rsp_status),
    .rsp_pa         (rsp_pa),
    .rsp_attr       (rsp_attr),
    .flt_pending    (flt_pending),
    .flt_va         (flt_va),
    .flt_write      (flt_write),
    .flt_ack        (flt_ack),
    .bus_err        (bus_err),
    .tlb_hit        (tlb_hit),
    .tlb_ent        (tlb_ent),
    .fill_en        (fill_en),
    .fill_ent       (fill_ent),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_addr   (mem_req_addr),
    .mem_rsp_valid  (mem_rsp_valid),
    .mem_rsp_data   (mem_rsp_data),
    .mem_rsp_err    (mem_rsp_err)
  );
endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
  localparam logic [19:0] BASE_FR = 20'h00100;
  localparam logic [31:0] BASE    = {BASE_FR, 12'h000};
  localparam logic [31:0] PT_A    = 32'h0020_0000;
  localparam logic [31:0] PT_B    = 32'h0020_1000;
  localparam logic [31:0] PT_C    = 32'h0020_2000;

  logic clk = 0, rst_n = 0;
  logic stall = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1, flt_ack = 0;
  logic [31:0] req_va = 0;
  logic inv_page = 0, flush_all = 0;
  logic [19:0] inv_vpn = 0;
  logic mem_req_ready, mem_rsp_valid, mem_rsp_err;
  logic [31:0] mem_rsp_data;
  logic req_ready, rsp_valid, flt_pending, flt_write, bus_err, mem_req_valid;
  logic [1:0] rsp_status;
  logic [31:0] rsp_pa, flt_va, mem_req_addr;
  logic [7:0] rsp_attr;

  always #5 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .stall(stall), .dir_base_frame(BASE_FR),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .rsp_pa(rsp_pa), .rsp_attr(rsp_attr), .flt_pending(flt_pending), .flt_va(flt_va),
    .flt_write(flt_write), .flt_ack(flt_ack), .bus_err(bus_err), .inv_page(inv_page),
    .inv_vpn(inv_vpn), .flush_all(flush_all), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] mem_img [logic [31:0]];
  bit          berr_set [logic [31:0]];
  int          rd_count = 0;
  logic [31:0] last_addr [2];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_word(input logic [31:0] a);
    return mem_img.exists(a) ? mem_img[a] : 32'h0;
  endfunction

  function automatic logic [31:0] mk_va(input int d, input int p, input int off);
    return {10'(d), 10'(p), 12'(off)};
  endfunction

  task automatic set_dte(input int d, input logic [31:0] pt, input bit v);
    mem_img[BASE + 32'(d) * 4] = {pt[31:12], 11'h0, v};
  endtask

  task automatic set_pte(input logic [31:0] pt, input int i, input logic [19:0] ppn,
                         input logic [7:0] attr, input bit v);
    mem_img[pt + 32'(i) * 4] = {ppn, 3'b000, attr, v};
  endtask

  // expected result from the requirements alone
  function automatic void ref_walk(input logic [31:0] va, input bit wr, output logic [1:0] st,
                                   output logic [31:0] pa, output logic [7:0] at);
    logic [31:0] da, d, pta, p;
    st = 2'd0; pa = 0; at = 0;
    da = BASE + 32'(va[31:22]) * 4;
    if (berr_set.exists(da)) begin st = 2'd2; return; end
    d = rd_word(da);
    if (!d[0]) begin st = 2'd1; return; end
    pta = {d[31:12], 12'h0} + 32'(va[21:12]) * 4;
    if (berr_set.exists(pta)) begin st = 2'd2; return; end
    p = rd_word(pta);
    if (!p[0] || !(wr ? p[2] : p[1])) begin st = 2'd1; return; end
    pa = {p[31:12], va[11:0]};
    at = p[8:1];
  endfunction

  // memory model: random ready, 1..3 cycles latency
  initial begin
    bit took = 0, pend = 0;
    logic [31:0] t_addr = 0, p_addr = 0;
    int p_cnt = 0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0; mem_rsp_err = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0; mem_rsp_err = 0;
      if (took) begin
        pend = 1; p_addr = t_addr; p_cnt = $urandom_range(0, 2); took = 0;
        rd_count++; last_addr[1] = last_addr[0]; last_addr[0] = t_addr;
      end else if (pend) begin
        if (p_cnt == 0) begin
          mem_rsp_valid = 1; mem_rsp_data = rd_word(p_addr);
          mem_rsp_err = berr_set.exists(p_addr); pend = 0;
        end else p_cnt--;
      end
      mem_req_ready = pend ? 1'b0 : ($urandom_range(0, 3) != 0);
      if (mem_req_valid && mem_req_ready) begin took = 1; t_addr = mem_req_addr; end
    end
  end

  task automatic xlate(input logic [31:0] va, input bit wr, input int hold,
                       output logic [1:0] st, output logic [31:0] pa, output logic [7:0] at,
                       output int nrd, output int lat, output bit berr);
    int rd0;
    rd0 = rd_count;
    @(negedge clk);
    req_valid = 1; req_va = va; req_write = wr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0; lat = 0;
    rsp_ready = (hold == 0);
    while (!rsp_valid && lat < 500) begin @(negedge clk); lat++; end
    st = rsp_status; pa = rsp_pa; at = rsp_attr; berr = bus_err;
    chk("R11", "req_ready while response pending", {31'h0, req_ready}, 32'h0);
    if (hold > 0) begin
      repeat (hold) begin
        @(negedge clk);
        chk("R12", "rsp_valid held", {31'h0, rsp_valid}, 32'h1);
        chk("R12", "rsp_pa held", rsp_pa, pa);
      end
      rsp_ready = 1;
    end
    @(negedge clk);
    nrd = rd_count - rd0;
  endtask

  task automatic ack_fault(input string req, input logic [31:0] va, input bit wr);
    chk(req, "flt_pending", {31'h0, flt_pending}, 32'h1);
    chk(req, "flt_va", flt_va, va);
    chk(req, "flt_write", {31'h0, flt_write}, {31'h0, wr});
    chk("R5", "req_ready during fault", {31'h0, req_ready}, 32'h0);
    @(negedge clk); flt_ack = 1;
    @(negedge clk); flt_ack = 0;
    chk("R5", "fault cleared", {31'h0, flt_pending}, 32'h0);
  endtask

  task automatic pulse_inv(input logic [19:0] vpn);
    @(negedge clk); inv_page = 1; inv_vpn = vpn;
    @(negedge clk); inv_page = 0;
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush_all = 1;
    @(negedge clk); flush_all = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [1:0] st, est;
    logic [31:0] pa, epa, va;
    logic [7:0] at, eat;
    int nrd, lat;
    bit berr;
    void'($urandom(32'd1234));

    // memory image
    set_dte(1, PT_A, 1);
    set_dte(2, PT_B, 1);
    set_dte(4, PT_C, 1);
    set_pte(PT_A, 5, 20'hABCDE, 8'h13, 1);   // readable+writable
    set_pte(PT_A, 6, 20'h12345, 8'h03, 0);   // invalid page
    set_pte(PT_A, 8, 20'h22222, 8'h01, 1);   // read only
    set_pte(PT_A, 9, 20'h33333, 8'h02, 1);   // write only
    for (int i = 20; i < 29; i++) set_pte(PT_A, i, 20'h40000 + 20'(i), 8'h03, 1);
    set_pte(PT_B, 0, 20'h55555, 8'h03, 1);
    berr_set[PT_B] = 1;                          // page word read fails
    berr_set[BASE + 32'd3 * 4] = 1;              // directory word read fails
    for (int i = 0; i < 32; i++)
      set_pte(PT_C, i, 20'($urandom), 8'($urandom_range(0, 3)), $urandom_range(0, 3) != 0);

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R13", "req_ready after reset", {31'h0, req_ready}, 32'h1);
    chk("R13", "rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
    chk("R13", "mem_req_valid after reset", {31'h0, mem_req_valid}, 32'h0);
    chk("R13", "flt_pending after reset", {31'h0, flt_pending}, 32'h0);
    chk("R13", "bus_err after reset", {31'h0, bus_err}, 32'h0);

    // R1 R2: full walk
    va = mk_va(1, 5, 12'h123);
    xlate(va, 0, 0, st, pa, at, nrd, lat, berr);
    chk("R2", "status", {30'h0, st}, 32'h0);
    chk("R2", "pa", pa, 32'hABCDE123);
    chk("R2", "attr", {24'h0, at}, 32'h13);
    chk("R2", "reads on miss", nrd, 2);
    chk("R1", "directory address", last_addr[1], BASE + 32'd4);
    chk("R2", "page word address", last_addr[0], PT_A + 32'd20);

    // R7: hit, one cycle, no memory
    xlate(mk_va(1, 5, 12'hFFF), 1, 0, st, pa, at, nrd, lat, berr);
    chk("R7", "hit pa", pa, 32'hABCDEFFF);
    chk("R7", "hit reads", nrd, 0);
    chk("R7", "hit latency", lat, 0);

    // R3: invalid directory word
    va = mk_va(7, 1, 12'h010);
    xlate(va, 1, 0, st, pa, at, nrd, lat, berr);
    chk("R3", "invalid dir status", {30'h0, st}, 32'h1);
    chk("R3", "invalid dir reads", nrd, 1);
    ack_fault("R5", va, 1);

    // R3: invalid page word
    va = mk_va(1, 6, 12'h004);
    xlate(va, 0, 0, st, pa, at, nrd, lat, berr);
    chk("R3", "invalid page status", {30'h0, st}, 32'h1);
    chk("R3", "invalid page pa", pa, 32'h0);
    ack_fault("R5", va, 0);

    // R4: permission on walk and on hit
    xlate(mk_va(1, 8, 12'h008), 0, 0, st, pa, at, nrd, lat, berr);
    chk("R4", "read-only read", {30'h0, st}, 32'h0);
    va = mk_va(1, 8, 12'h00C);
    xlate(va, 1, 0, st, pa, at, nrd, lat, berr);
    chk("R4", "read-only write status", {30'h0, st}, 32'h1);
    chk("R4", "hit-path fault reads", nrd, 0);
    ack_fault("R4", va, 1);
    va = mk_va(1, 9, 12'h000);
    xlate(va, 0, 0, st, pa, at, nrd, lat, berr);
    chk("R4", "write-only read status", {30'h0, st}, 32'h1);
    ack_fault("R4", va, 0);

    // R6: bus errors on each level
    xlate(mk_va(3, 0, 0), 0, 0, st, pa, at, nrd, lat, berr);
    chk("R6", "dir bus error status", {30'h0, st}, 32'h2);
    chk("R6", "bus_err pulse", {31'h0, berr}, 32'h1);
    chk("R6", "no fault pending", {31'h0, flt_pending}, 32'h0);
    chk("R6", "bus_err dropped", {31'h0, bus_err}, 32'h0);
    xlate(mk_va(2, 0, 0), 1, 0, st, pa, at, nrd, lat, berr);
    chk("R6", "page bus error status", {30'h0, st}, 32'h2);
    chk("R6", "page bus error reads", nrd, 2);

    // R11: stall
    @(negedge clk); stall = 1; req_valid = 1; req_va = mk_va(1, 5, 0);
    repeat (4) begin
      @(negedge clk);
      chk("R11", "req_ready under stall", {31'h0, req_ready}, 32'h0);
      chk("R11", "no walk under stall", {31'h0, mem_req_valid | rsp_valid}, 32'h0);
    end
    req_valid = 0; stall = 0;

    // R12: back-pressure on a hit
    xlate(mk_va(1, 5, 12'h777), 0, 4, st, pa, at, nrd, lat, berr);
    chk("R12", "pa after hold", pa, 32'hABCDE777);

    // R9: page invalidate
    set_pte(PT_A, 5, 20'h11111, 8'h03, 1);
    xlate(mk_va(1, 5, 12'h001), 0, 0, st, pa, at, nrd, lat, berr);
    chk("R9", "stale hit before invalidate", pa, 32'hABCDE001);
    pulse_inv(mk_va(1, 5, 0) >> 12);
    xlate(mk_va(1, 5, 12'h001), 0, 0, st, pa, at, nrd, lat, berr);
    chk("R9", "new pa after invalidate", pa, 32'h11111001);
    chk("R9", "invalidated page reads", nrd, 2);
    xlate(mk_va(1, 8, 12'h002), 0, 0, st, pa, at, nrd, lat, berr);
    chk("R9", "other page still cached", nrd, 0);

    // R10: full clear
    pulse_flush();
    xlate(mk_va(1, 5, 0), 0, 0, st, pa, at, nrd, lat, berr);
    chk("R10", "reads after flush (a)", nrd, 2);
    xlate(mk_va(1, 8, 0), 0, 0, st, pa, at, nrd, lat, berr);
    chk("R10", "reads after flush (b)", nrd, 2);

    // R8: round robin eviction
    pulse_flush();
    for (int i = 20; i < 29; i++) xlate(mk_va(1, i, 0), 0, 0, st, pa, at, nrd, lat, berr);
    xlate(mk_va(1, 21, 0), 0, 0, st, pa, at, nrd, lat, berr);
    chk("R8", "second page kept", nrd, 0);
    xlate(mk_va(1, 20, 12'h0AB), 0, 0, st, pa, at, nrd, lat, berr);
    chk("R8", "first page evicted", nrd, 2);
    chk("R8", "evicted page pa", pa, 32'h400140AB);

    // random traffic against fixed tables
    pulse_flush();
    for (int n = 0; n < 120; n++) begin
      bit wr;
      int d;
      d  = ($urandom_range(0, 5) == 0) ? 5 : 4;
      va = mk_va(d, $urandom_range(0, 31), $urandom_range(0, 4095));
      wr = $urandom_range(0, 1);
      ref_walk(va, wr, est, epa, eat);
      xlate(va, wr, $urandom_range(0, 2), st, pa, at, nrd, lat, berr);
      chk("R2", "random status", {30'h0, st}, {30'h0, est});
      chk("R2", "random pa", pa, epa);
      chk("R4", "random attr", {24'h0, at}, {24'h0, eat});
      if (est == 2'd1) ack_fault("R5", va, wr);
    end

    summary();
  end
endmodule